// File: doc/BRIEF.md
# Next Fetch Address Sequencer

This block owns the program counter of a simple 32-bit fetch stage and selects, once per clock, the address the stage fetches next. A decoder upstream presents a control class for the instruction at the current address. The class says whether the stream advances sequentially, branches conditionally on an equality result, jumps inside the current 256 MB region, jumps and saves a return address, or loads the counter from a register operand. Alongside the class come the 16-bit branch immediate, the 26-bit jump field, the register operand and the equality flag produced by comparing the two branch operands.

Branch displacements count 32-bit words and are measured from the address after the branch. Direct jumps replace the low 28 bits of the address and keep the top four bits of the sequential successor, so they cannot leave their 256 MB region. On a jump-and-link the sequencer hands the sequential successor to the register file as a return address, with a write enable that lasts one cycle. All outputs are registered. A synchronous active-high reset loads a configurable start address.

Top module: `fetch_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes `START_ADDR` (default 32'h0040_0000) and `link_en_o` becomes 0, whatever the control class.
- R2: Class code 0 (sequential) makes the next `pc_o` equal the current `pc_o` + 4, modulo 2^32.
- R3: Class code 1 (branch-if-equal) with `eq_i`=1 makes the next `pc_o` equal `pc_o` + 4 + (sign-extended `imm_i` shifted left by 2). With `eq_i`=0 it makes the next `pc_o` equal `pc_o` + 4.
- R4: Class code 2 (branch-if-not-equal) is taken when `eq_i`=0 and not taken when `eq_i`=1, with the same target and fall-through as R3. A branch at 80008 with immediate 2 that is taken goes to 80020.
- R5: Class code 3 (direct jump) makes the next `pc_o` equal {bits 31..28 of (`pc_o`+4), `jfield_i`, 2'b00}.
- R6: Class code 4 (jump-and-link) moves `pc_o` as in R5. In the following cycle `link_val_o` holds the old `pc_o` + 4 and `link_en_o` is 1. The destination is register 31.
- R7: Class code 5 (register jump) loads `pc_o` with `reg_val_i` unchanged, including its two low bits.
- R8: Class codes 6 and 7 act exactly like code 0. Inputs that the presented class does not use (`eq_i`, `imm_i`, `jfield_i`, `reg_val_i`) do not affect the next `pc_o`.
- R9: `link_en_o` is 0 in the cycle after any class other than code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctl_i | input | 3 | Control class of the current instruction (codes in R2 to R8) |
| imm_i | input | 16 | Branch displacement in words, two's complement |
| jfield_i | input | 26 | Direct-jump word address field |
| reg_val_i | input | 32 | Register operand for register jumps |
| eq_i | input | 1 | Compared branch operands are equal |
| pc_o | output | 32 | Current program counter |
| link_val_o | output | 32 | Return address for the link register |
| link_en_o | output | 1 | Write enable for the link register |

## Verification
The assertions check every cycle that the sequential and untaken-branch cases advance by four, that direct jumps keep the successor's region bits and the jump field with zero low bits, that register jumps copy the operand, and that the link enable and return value follow exactly the jump-and-link class. The taken-branch arithmetic over the full signed displacement range, the 256 MB region boundary and wraparound at the top of the address space, and the indifference to unused inputs are shown only by the bench sweeps, which preload chosen counter values and compare every class and flag combination against an arithmetic model.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int CTL_W = 3;

  typedef enum logic [CTL_W-1:0] {
    CTL_SEQ  = 3'd0,
    CTL_BEQ  = 3'd1,
    CTL_BNE  = 3'd2,
    CTL_JMP  = 3'd3,
    CTL_JAL  = 3'd4,
    CTL_JREG = 3'd5
  } ctl_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_JMP = 2'd2,
    SRC_REG = 2'd3
  } npc_src_e;

endpackage

// File: rtl/fseq_incr.sv
module fseq_incr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] succ_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_comb succ_o = addr_i + STEP_V;
endmodule

// File: rtl/fseq_branch_tgt.sv
module fseq_branch_tgt #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] succ_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int EXT_W = ADDR_W - IMM_W - ALIGN;

  logic [ADDR_W-1:0] byte_ofs;

  generate
    if (EXT_W > 0) begin : g_ext
      always_comb byte_ofs = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN{1'b0}}};
    end else begin : g_trunc
      logic [IMM_W+ALIGN-1:0] wide;
      always_comb begin
        wide     = {imm_i, {ALIGN{1'b0}}};
        byte_ofs = wide[ADDR_W-1:0];
      end
    end
  endgenerate

  always_comb tgt_o = succ_i + byte_ofs;
endmodule

// File: rtl/fseq_jump_tgt.sv
module fseq_jump_tgt #(
  parameter int ADDR_W = 32,
  parameter int JF_W   = 26,
  parameter int ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] succ_i,
  input  logic [JF_W-1:0]   jfield_i,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int REGION_W = ADDR_W - JF_W - ALIGN;

  generate
    if (REGION_W > 0) begin : g_region
      always_comb tgt_o = {succ_i[ADDR_W-1 -: REGION_W], jfield_i, {ALIGN{1'b0}}};
    end else begin : g_flat
      always_comb tgt_o = {jfield_i[ADDR_W-ALIGN-1:0], {ALIGN{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/fseq_npc_sel.sv
module fseq_npc_sel
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic              eq_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] br_i,
  input  logic [ADDR_W-1:0] jmp_i,
  input  logic [ADDR_W-1:0] reg_i,
  output logic [ADDR_W-1:0] npc_o,
  output logic              link_o
);
  ctl_e     cls;
  npc_src_e src;

  always_comb begin
    cls    = ctl_e'(ctl_i);
    src    = SRC_SEQ;
    link_o = 1'b0;
    case (cls)
      CTL_BEQ:  src = eq_i  ? SRC_BR : SRC_SEQ;
      CTL_BNE:  src = !eq_i ? SRC_BR : SRC_SEQ;
      CTL_JMP:  src = SRC_JMP;
      CTL_JAL: begin
        src    = SRC_JMP;
        link_o = 1'b1;
      end
      CTL_JREG: src = SRC_REG;
      default:  src = SRC_SEQ;
    endcase
  end

  always_comb begin
    case (src)
      SRC_BR:  npc_o = br_i;
      SRC_JMP: npc_o = jmp_i;
      SRC_REG: npc_o = reg_i;
      default: npc_o = seq_i;
    endcase
  end
endmodule

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq
  import fseq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              IMM_W      = 16,
  parameter int              JF_W       = 26,
  parameter logic [ADDR_W-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JF_W-1:0]   jfield_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  input  logic              eq_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] link_val_o,
  output logic              link_en_o
);
  localparam int ALIGN = 2;
  localparam int STEP  = 1 << ALIGN;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] succ;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] jmp_tgt;
  logic [ADDR_W-1:0] npc;
  logic              do_link;
  logic [ADDR_W-1:0] link_q;
  logic              link_en_q;

  fseq_incr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_incr (
    .addr_i (pc_q),
    .succ_o (succ)
  );

  fseq_branch_tgt #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ALIGN(ALIGN)) u_br (
    .succ_i (succ),
    .imm_i  (imm_i),
    .tgt_o  (br_tgt)
  );

  fseq_jump_tgt #(.ADDR_W(ADDR_W), .JF_W(JF_W), .ALIGN(ALIGN)) u_jmp (
    .succ_i   (succ),
    .jfield_i (jfield_i),
    .tgt_o    (jmp_tgt)
  );

  fseq_npc_sel #(.ADDR_W(ADDR_W)) u_sel (
    .ctl_i  (ctl_i),
    .eq_i   (eq_i),
    .seq_i  (succ),
    .br_i   (br_tgt),
    .jmp_i  (jmp_tgt),
    .reg_i  (reg_val_i),
    .npc_o  (npc),
    .link_o (do_link)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= START_ADDR;
      link_q    <= '0;
      link_en_q <= 1'b0;
    end else begin
      pc_q      <= npc;
      link_en_q <= do_link;
      if (do_link) link_q <= succ;
    end
  end

  assign pc_o       = pc_q;
  assign link_val_o = link_q;
  assign link_en_o  = link_en_q;
endmodule

// File: rtl/fetch_addr_seq_chk.sv
module fetch_addr_seq_chk #(
  parameter int              ADDR_W     = 32,
  parameter int              IMM_W      = 16,
  parameter int              JF_W       = 26,
  parameter logic [ADDR_W-1:0] START_ADDR = 32'h0040_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        ctl_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [JF_W-1:0]   jfield_i,
  input logic [ADDR_W-1:0] reg_val_i,
  input logic              eq_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] link_val_o,
  input logic              link_en_o
);
  localparam int RGN_W = ADDR_W - JF_W - 2;

  logic [ADDR_W-1:0] nxt;
  assign nxt = pc_o + ADDR_W'(4);

  // R1
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (pc_o == START_ADDR && !link_en_o));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd0) |=> (pc_o == $past(nxt)));

  // R3
  beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd1 && !eq_i) |=> (pc_o == $past(nxt)));

  // R4
  bne_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd2 && eq_i) |=> (pc_o == $past(nxt)));

  // R5
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd3 || ctl_i == 3'd4) |=>
      (pc_o[ADDR_W-1 -: RGN_W] == $past(nxt[ADDR_W-1 -: RGN_W]) &&
       pc_o[ADDR_W-RGN_W-1:2] == $past(jfield_i) && pc_o[1:0] == 2'b00));

  // R6
  link_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd4) |=> (link_en_o && link_val_o == $past(nxt)));

  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd5) |=> (pc_o == $past(reg_val_i)));

  // R8
  spare_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd6 || ctl_i == 3'd7) |=> (pc_o == $past(nxt)));

  // R9
  no_link_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_i != 3'd4) |=> !link_en_o);
endmodule

bind fetch_addr_seq fetch_addr_seq_chk #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .JF_W(JF_W), .START_ADDR(START_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .ctl_i(ctl_i), .imm_i(imm_i), .jfield_i(jfield_i),
  .reg_val_i(reg_val_i), .eq_i(eq_i), .pc_o(pc_o), .link_val_o(link_val_o),
  .link_en_o(link_en_o)
);

// File: tb/sim_fetch_addr_seq.sv
`timescale 1ns/1ps
module sim_fetch_addr_seq;
  localparam logic [31:0] START = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ctl = 3'd0;
  logic [15:0] imm = '0;
  logic [25:0] jf  = '0;
  logic [31:0] rv  = '0;
  logic        eq  = 1'b0;
  logic [31:0] pc, lval;
  logic        len;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fetch_addr_seq #(.START_ADDR(START)) u0 (
    .clk(clk), .rst(rst), .ctl_i(ctl), .imm_i(imm), .jfield_i(jf),
    .reg_val_i(rv), .eq_i(eq), .pc_o(pc), .link_val_o(lval), .link_en_o(len)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] c, input logic e,
      input logic [15:0] im, input logic [25:0] j, input logic [31:0] r,
      input logic [31:0] p);
    logic [31:0] s;
    logic [31:0] ofs;
    s   = p + 32'd4;
    ofs = {{14{im[15]}}, im, 2'b00};
    case (c)
      3'd1:    return e  ? s + ofs : s;
      3'd2:    return !e ? s + ofs : s;
      3'd3,
      3'd4:    return {s[31:28], j, 2'b00};
      3'd5:    return r;
      default: return s;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // drive after a falling edge, observe after the next falling edge
  task automatic step(input logic [2:0] c, input logic e, input logic [15:0] im,
      input logic [25:0] j, input logic [31:0] r);
    ctl = c; eq = e; imm = im; jf = j; rv = r;
    @(negedge clk);
  endtask

  task automatic preload(input logic [31:0] p);
    step(3'd5, 1'b0, 16'h0, 26'h0, p);
    chk("R7 preload", pc, p);
    chk("R9 after jreg", {31'd0, len}, 32'd0);
  endtask

  logic [31:0] pcs  [6] = '{START, 32'h0, 32'hFFFF_FFFC, 32'h1FFF_FFFC,
                            32'd80008, 32'h7FFF_0000};
  logic [15:0] imms [6] = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF,
                            16'h7FFF, 16'h8000};

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset pc", pc, START);
    chk("R1 reset link_en", {31'd0, len}, 32'd0);
    rst = 1'b0;

    // worked example: branch-not-equal at 80008, immediate 2
    preload(32'd80008);
    step(3'd2, 1'b0, 16'd2, 26'h0, 32'h0);
    chk("R4 example", pc, 32'd80020);

    for (int pi = 0; pi < 6; pi++) begin
      for (int ii = 0; ii < 6; ii++) begin
        for (int c = 0; c < 8; c++) begin
          for (int e = 0; e < 2; e++) begin
            logic [31:0] p0, r0, expv;
            logic [25:0] j0;
            p0 = pcs[pi];
            j0 = 26'h2AA_AAAA ^ 26'(pi * 977 + ii * 31 + c);
            r0 = 32'hDEAD_BEE1 + 32'(ii * 4 + c);
            preload(p0);
            expv = model(3'(c), e[0], imms[ii], j0, r0, p0);
            step(3'(c), e[0], imms[ii], j0, r0);
            chk(tag(3'(c)), pc, expv);
            if (c == 4) begin
              chk("R6 link_en", {31'd0, len}, 32'd1);
              chk("R6 link_val", lval, p0 + 32'd4);
            end else begin
              chk("R9 link_en", {31'd0, len}, 32'd0);
            end
          end
        end
      end
    end

    // unused inputs have no effect on sequential and jump classes
    preload(32'h0000_1000);
    step(3'd0, 1'b1, 16'hFFFF, 26'h3FF_FFFF, 32'h1234_5678);
    chk("R8 unused inputs seq", pc, 32'h0000_1004);
    step(3'd3, 1'b1, 16'h8000, 26'h000_0010, 32'hFFFF_FFFF);
    chk("R8 unused inputs jump", pc, 32'h0000_0040);

    // reset overrides a jump-and-link
    step(3'd4, 1'b0, 16'h0, 26'h100, 32'h0);
    chk("R6 link before reset", {31'd0, len}, 32'd1);
    rst = 1'b1;
    step(3'd4, 1'b0, 16'h0, 26'h200, 32'h0);
    chk("R1 reset pc mid-run", pc, START);
    chk("R1 reset link_en mid-run", {31'd0, len}, 32'd0);
    rst = 1'b0;
    step(3'd0, 1'b0, 16'h0, 26'h0, 32'h0);
    chk("R2 after reset", pc, START + 32'd4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule